// File: doc/BRIEF.md
# Dual Wiper Register Bank with Deferred Nonvolatile Commit

This block keeps the control state of a two-channel digital potentiometer: one 6-bit tap position for each channel and one byte that holds a 3-bit amplifier gain code for each channel. It sits behind a serial-bus slave front end, which hands it single-cycle write strobes (register address and data byte, raised when the data byte is acknowledged), read requests, and single-cycle pulses that mark a stop condition or a repeated start condition. Every accepted write reaches the live outputs on the next clock edge.

Each live register has a backing "nonvolatile" copy, modelled as ordinary flops that synchronous reset does not clear. An accepted write arms a commit. A stop condition fires it and copies the live state into the backing copy. A repeated start disarms it, so the update stays volatile. After a commit, a busy flag stays high for a parameterised number of clock cycles to stand for the storage write time. While that flag is high, and whenever write-protect is high, writes are refused. Reset stands for power-up: it reloads the live registers from the backing copy. On the very first power-up the backing copy holds the factory defaults.

Top module: `wiper_regbank`

## Requirements
- R1: On reset the live state is loaded from the backing copy; at first power-up both wipers read 1Fh and the gain byte reads 11h.
- R2: An accepted write to address F8h (wiper 0) or F9h (wiper 1) sets that wiper to data bits [5:0] on the next clock edge; bits [7:6] are discarded.
- R3: An accepted write to FAh loads data bits [5:0] into both wipers at once; a read of FAh returns 00h.
- R4: An accepted write to FBh stores the gain byte with bits 7 and 3 forced to zero; reading FBh returns the stored byte, and reading F8h/F9h returns {2'b00, wiper}.
- R5: Each gain select output is one-hot: bit0 = gain 1 for code 00x, bit1 = gain 2 for code 01x, bit2 = gain 4 for code 1xx; channel 0 uses byte bits [2:0], channel 1 uses bits [6:4].
- R6: Read data appears on rd_data one cycle after rd_en; unmapped addresses read 00h, and writes to them change nothing.
- R7: A stop pulse after at least one accepted write copies the live state into the backing copy and holds busy high for exactly BUSY_CYCLES cycles.
- R8: A repeated start pulse after an accepted write cancels the commit: busy stays low, and a later reset restores the previously committed state.
- R9: While wprot is high, writes are ignored and arm no commit; reads still return the stored values.
- R10: While busy is high, writes are ignored.
- R11: A stop pulse with no armed write leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up recall) |
| wr_en | input | 1 | Write strobe, one cycle per acknowledged data byte |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Data byte of the write |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Register address of the read |
| rd_data | output | 8 | Registered read data |
| stop_evt | input | 1 | One-cycle pulse on a bus stop condition |
| rstart_evt | input | 1 | One-cycle pulse on a repeated start condition |
| wprot | input | 1 | Write protect, high blocks all writes |
| wiper0 | output | 6 | Live tap position, channel 0 |
| wiper1 | output | 6 | Live tap position, channel 1 |
| gain_sel0 | output | 3 | One-hot gain select, channel 0 |
| gain_sel1 | output | 3 | One-hot gain select, channel 1 |
| busy | output | 1 | High while the storage write is in progress |

## Verification
The assertions assume that the front end raises stop_evt and rstart_evt as single-cycle pulses, never both in the same cycle, and never in the same cycle as wr_en. They also assume that reset is held from time zero until after the first clock edge. The bench drives every input on the falling edge, one pulse per task call, and always closes a write with exactly one of the two condition pulses in a later cycle, so these assumptions hold. BUSY_CYCLES is overridden to a small value so that the whole busy window can be counted.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_WIPER0 = 8'hF8;
  localparam logic [ADDR_W-1:0] A_WIPER1 = 8'hF9;
  localparam logic [ADDR_W-1:0] A_BOTH   = 8'hFA;
  localparam logic [ADDR_W-1:0] A_GAIN   = 8'hFB;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_W0,
    TGT_W1,
    TGT_BOTH,
    TGT_GAIN
  } tgt_e;
endpackage

// File: rtl/regbank_addr_dec.sv
module regbank_addr_dec
  import wiper_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt
);
  always_comb begin
    unique case (addr)
      A_WIPER0: tgt = TGT_W0;
      A_WIPER1: tgt = TGT_W1;
      A_BOTH:   tgt = TGT_BOTH;
      A_GAIN:   tgt = TGT_GAIN;
      default:  tgt = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/gain_decoder.sv
module gain_decoder #(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code,
  output logic [2:0]        sel
);
  always_comb begin
    if (code[2])      sel = 3'b100;
    else if (code[1]) sel = 3'b010;
    else              sel = 3'b001;
  end
endmodule

// File: rtl/commit_timer.sv
module commit_timer #(
  parameter int BUSY_CYCLES = 2_000_000,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_set,
  input  logic stop_evt,
  input  logic rstart_evt,
  output logic fire,
  output logic busy
);
  logic             armed;
  logic [CNT_W-1:0] cnt;

  assign fire = stop_evt && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (rstart_evt || stop_evt) begin
      armed <= 1'b0;
    end else if (arm_set) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (fire) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(BUSY_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wiper_regbank.sv
module wiper_regbank
  import wiper_pkg::*;
#(
  parameter int               POS_W       = 6,
  parameter int               BUSY_CYCLES = 2_000_000,
  parameter logic [POS_W-1:0] POS_DEFAULT = 6'h1F,
  parameter logic [7:0]       GAIN_DEFAULT = 8'h11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stop_evt,
  input  logic              rstart_evt,
  input  logic              wprot,
  output logic [POS_W-1:0]  wiper0,
  output logic [POS_W-1:0]  wiper1,
  output logic [2:0]        gain_sel0,
  output logic [2:0]        gain_sel1,
  output logic              busy
);
  localparam int CHANNELS = 2;
  localparam int NIBBLE   = DATA_W / CHANNELS;
  localparam int CODE_W   = NIBBLE - 1;

  tgt_e wr_tgt, rd_tgt;
  logic wr_ok, fire;
  logic [DATA_W-1:0] gain_q, gain_n, gain_clean;
  logic [DATA_W-1:0] nv_gain = GAIN_DEFAULT;
  logic [POS_W-1:0]  nv_w0   = POS_DEFAULT;
  logic [POS_W-1:0]  nv_w1   = POS_DEFAULT;
  logic [2:0]        sel_n [CHANNELS];

  regbank_addr_dec u_wdec (.addr(wr_addr), .tgt(wr_tgt));
  regbank_addr_dec u_rdec (.addr(rd_addr), .tgt(rd_tgt));

  assign wr_ok = wr_en && !wprot && !busy && (wr_tgt != TGT_NONE);

  commit_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_commit (
    .clk(clk), .rst(rst), .arm_set(wr_ok), .stop_evt(stop_evt),
    .rstart_evt(rstart_evt), .fire(fire), .busy(busy)
  );

  // reserved top bit of each nibble is cleared on the way in
  always_comb begin
    for (int c = 0; c < CHANNELS; c++) begin
      gain_clean[c*NIBBLE +: NIBBLE] = {1'b0, wr_data[c*NIBBLE +: CODE_W]};
    end
  end

  always_comb begin
    if (rst)                             gain_n = nv_gain;
    else if (wr_ok && wr_tgt == TGT_GAIN) gain_n = gain_clean;
    else                                 gain_n = gain_q;
  end

  generate
    for (genvar g = 0; g < CHANNELS; g++) begin : g_gain
      gain_decoder #(.CODE_W(CODE_W)) u_gdec (
        .code(gain_n[g*NIBBLE +: CODE_W]), .sel(sel_n[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    gain_q    <= gain_n;
    gain_sel0 <= sel_n[0];
    gain_sel1 <= sel_n[1];
    if (rst) begin
      wiper0 <= nv_w0;
      wiper1 <= nv_w1;
    end else if (wr_ok) begin
      if (wr_tgt == TGT_W0 || wr_tgt == TGT_BOTH) wiper0 <= wr_data[POS_W-1:0];
      if (wr_tgt == TGT_W1 || wr_tgt == TGT_BOTH) wiper1 <= wr_data[POS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      nv_w0   <= wiper0;
      nv_w1   <= wiper1;
      nv_gain <= gain_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      unique case (rd_tgt)
        TGT_W0:   rd_data <= DATA_W'(wiper0);
        TGT_W1:   rd_data <= DATA_W'(wiper1);
        TGT_GAIN: rd_data <= gain_q;
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wiper_regbank_chk.sv
module wiper_regbank_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] rd_data,
  input logic       rd_en,
  input logic [7:0] rd_addr,
  input logic       stop_evt,
  input logic       rstart_evt,
  input logic       wprot,
  input logic [5:0] wiper0,
  input logic [5:0] wiper1,
  input logic [2:0] gain_sel0,
  input logic [2:0] gain_sel1,
  input logic       busy
);
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    busy && wr_en |=> $stable(wiper0) && $stable(wiper1));

  a_r9_wprot_blocks: assert property (@(posedge clk) disable iff (rst)
    wprot && wr_en |=> $stable(wiper0) && $stable(wiper1)
                    && $stable(gain_sel0) && $stable(gain_sel1));

  a_r5_gain_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(gain_sel0) == 1 && $countones(gain_sel1) == 1);

  a_r7_busy_after_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_evt));

  a_r8_rstart_no_busy: assert property (@(posedge clk) disable iff (rst)
    rstart_evt && !stop_evt |=> !$rose(busy));

  a_r3_both_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_addr == 8'hFA |=> rd_data == 8'h00);
endmodule

bind wiper_regbank wiper_regbank_chk u_chk (.*);

// File: tb/wiper_regbank_test.sv
module wiper_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NBUSY = 8;
  localparam int NVEC = 6;
  // {addr, data, expected wiper0, expected wiper1}
  localparam logic [31:0] VEC [NVEC] = '{
    32'hF8_C2_02_1F, 32'hF9_7F_02_3F, 32'hFA_15_15_15,
    32'hF7_2A_15_15, 32'hF8_40_00_15, 32'hF9_A9_00_29
  };

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, stop_evt = 0, rstart_evt = 0, wprot = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, rd_addr = 0, rd_data;
  logic [5:0] wiper0, wiper1;
  logic [2:0] gain_sel0, gain_sel1;
  logic busy;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_regbank #(.BUSY_CYCLES(NBUSY)) uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_evt = 1;
    @(negedge clk); stop_evt = 0;
  endtask

  task automatic pulse_rstart();
    @(negedge clk); rstart_evt = 1;
    @(negedge clk); rstart_evt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    do_reset();
    // R1 first power-up defaults
    check("R1 w0", wiper0, 6'h1F);
    check("R1 w1", wiper1, 6'h1F);
    rd(8'hFB, d); check("R1 gain", d, 8'h11);
    check("R5 sel0 default x1", gain_sel0, 3'b001);
    check("R5 sel1 default x1", gain_sel1, 3'b001);

    // R2 R3 R6 vector walk, each write kept volatile
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][31:24], VEC[i][23:16]);
      check("R2/R3/R6 vec w0", wiper0, VEC[i][13:8]);
      check("R2/R3/R6 vec w1", wiper1, VEC[i][5:0]);
      pulse_rstart();
    end
    rd(8'hF9, d); check("R4 read wiper1", d, 8'h29);
    rd(8'hFA, d); check("R3 read FA", d, 8'h00);
    rd(8'hF0, d); check("R6 read unmapped", d, 8'h00);

    // R4 R5 gain byte
    wr(8'hFB, 8'hFF);
    rd(8'hFB, d); check("R4 reserved cleared", d, 8'h77);
    check("R5 sel0 x4", gain_sel0, 3'b100);
    check("R5 sel1 x4", gain_sel1, 3'b100);
    wr(8'hFB, 8'h23);
    check("R5 sel0 code3 x2", gain_sel0, 3'b010);
    check("R5 sel1 code2 x2", gain_sel1, 3'b010);
    wr(8'hFB, 8'h05);
    check("R5 sel0 code5 x4", gain_sel0, 3'b100);
    check("R5 sel1 code0 x1", gain_sel1, 3'b001);
    pulse_rstart();
    check("R8 no busy after rstart", busy, 1'b0);

    // R7 commit and busy length, R10 writes blocked while busy
    wr(8'hF8, 8'h0A);
    pulse_stop();
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    check("R7 busy cycles", n, NBUSY);
    pulse_stop();
    check("R11 idle stop no busy", busy, 1'b0);
    wr(8'hF8, 8'h10);
    pulse_stop();
    @(negedge clk); @(negedge clk);
    wr(8'hF9, 8'h11);
    check("R10 write ignored while busy", wiper1, 6'h29);
    while (busy) @(negedge clk);

    // R8 volatile update lost on reset
    wr(8'hF9, 8'h33);
    check("R8 volatile applied", wiper1, 6'h33);
    pulse_rstart();
    do_reset();
    check("R8 recall w0", wiper0, 6'h10);
    check("R8 recall w1", wiper1, 6'h29);
    rd(8'hFB, d); check("R1 recall gain", d, 8'h05);

    // R9 write protect
    wprot = 1;
    wr(8'hF8, 8'h3C);
    check("R9 write blocked", wiper0, 6'h10);
    pulse_stop();
    check("R9 no commit", busy, 1'b0);
    rd(8'hF8, d); check("R9 read allowed", d, 8'h10);
    wprot = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule